// File: doc/BRIEF.md
# Input Capture Unit with Noise Filter

This block timestamps transitions on an external capture pin. The pin is first brought into the clock domain by a synchronizer. An optional sample filter can then suppress short glitches, and an edge detector picks out transitions in a programmable direction. When a qualifying edge arrives, the current value of a free-running counter, which is supplied from outside, is latched into a capture register and a capture flag is raised. If the capture interrupt is enabled, the flag drives an interrupt request.

The block does not contain the counter, the waveform logic or the bus registers. A surrounding timer supplies the count, the control bits and a clear strobe for the flag. When the timer uses the capture register as its TOP value, it raises a gating input. That input disconnects the pin from the capture logic.

Top module: `icap_unit`

## Requirements
- R1: After a synchronous reset, `cap_value_o` is 0, `cap_flag_o` is 0 and `irq_o` is 0.
- R2: With the filter off, a pin change that is set up before clock edge j is captured at edge j+2. This is two synchronizer flops followed by the capture register. The value stored is the `count_i` present at edge j+2.
- R3: With `filt_en_i` = 1, the filtered level changes only after four consecutive synchronized samples all show the new level. A pulse on the pin that lasts fewer than four clock cycles produces no capture.
- R4: Turning the filter on delays a capture by exactly four clock cycles compared with the unfiltered path.
- R5: With `edge_rise_i` = 0 only falling edges (1 to 0) capture. With `edge_rise_i` = 1 only rising edges (0 to 1) capture. An edge in the other direction leaves the register and the flag unchanged.
- R6: A capture event copies `count_i` into `cap_value_o`, and the new value is visible after that clock edge.
- R7: A capture sets `cap_flag_o`. The flag stays set until a cycle with `flag_clr_i` = 1 clears it. If a capture and a clear fall in the same cycle, the flag stays set.
- R8: `irq_o` is a register loaded each cycle with the next flag value ANDed with `irq_en_i`. It therefore follows the flag in the same cycle, and follows a change of the enable one cycle later.
- R9: While `top_sel_i` = 1, no capture takes place and `cap_value_o` keeps its value. A pin level reached while gated does not cause a capture when the gate is lifted.
- R10: Toggling `edge_rise_i` while the pin level is steady produces no capture.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cap_pin_i | input | 1 | Asynchronous capture pin |
| count_i | input | CNT_W (16) | Free-running counter value to be captured |
| filt_en_i | input | 1 | 1 selects the four-sample filtered pin level |
| edge_rise_i | input | 1 | 1 captures on rising edges, 0 on falling edges |
| top_sel_i | input | 1 | 1 means the capture register serves as TOP, which disables capture |
| flag_clr_i | input | 1 | Write-one-to-clear strobe for the capture flag |
| irq_en_i | input | 1 | Capture interrupt enable |
| cap_value_o | output | CNT_W (16) | Captured counter value |
| cap_flag_o | output | 1 | Capture flag |
| irq_o | output | 1 | Capture interrupt request |

## Verification
Directed pin steps measure the delay from a pin change to the flag with the filter off and with it on. The two delays must differ by exactly four cycles. Pulses of one to three cycles, fed through the filter, must leave the flag untouched. Further directed cases cover edges in the wrong direction, pin changes while capture is gated, a flip of the edge select on a steady pin, and a clear that coincides with a capture. Random runs of varying length on the pin are then mixed with random changes to every control input and compared cycle by cycle against a model in the bench. These runs separate correct filter and gating behaviour from off-by-one timing.

// File: rtl/icap_pkg.sv
package icap_pkg;
  typedef enum logic {
    EDGE_FALL = 1'b0,
    EDGE_RISE = 1'b1
  } edge_dir_e;
endpackage

// File: rtl/icap_sync.sv
module icap_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk) begin
    if (rst) chain <= '0;
    else     chain <= {chain[STAGES-2:0], d_i};
  end

  assign q_o = chain[STAGES-1];
endmodule

// File: rtl/icap_filter.sv
module icap_filter #(
  parameter int LEN = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic d_i,
  output logic q_o
);
  localparam int HW = LEN - 1;

  logic [HW-1:0] hist;
  logic          q_r;
  logic          all_hi;
  logic          all_lo;

  always_comb begin
    all_hi = &{hist, d_i};
    all_lo = ~|{hist, d_i};
  end

  generate
    if (HW > 1) begin : g_multi
      always_ff @(posedge clk) begin
        if (rst) hist <= '0;
        else     hist <= {hist[HW-2:0], d_i};
      end
    end else begin : g_single
      always_ff @(posedge clk) begin
        if (rst) hist <= '0;
        else     hist <= d_i;
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst)         q_r <= 1'b0;
    else if (all_hi) q_r <= 1'b1;
    else if (all_lo) q_r <= 1'b0;
  end

  assign q_o = q_r;
endmodule

// File: rtl/icap_edge.sv
module icap_edge
  import icap_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      level_i,
  input  edge_dir_e dir_i,
  input  logic      gate_off_i,
  output logic      event_o
);
  logic prev;
  logic rise;
  logic fall;

  always_ff @(posedge clk) begin
    if (rst) prev <= 1'b0;
    else     prev <= level_i;
  end

  always_comb begin
    rise    = level_i & ~prev;
    fall    = ~level_i & prev;
    event_o = ~gate_off_i & ((dir_i == EDGE_RISE) ? rise : fall);
  end
endmodule

// File: rtl/icap_unit.sv
module icap_unit
  import icap_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int SYNC_STAGES = 2,
  parameter int FILT_LEN    = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cap_pin_i,
  input  logic [CNT_W-1:0] count_i,
  input  logic             filt_en_i,
  input  logic             edge_rise_i,
  input  logic             top_sel_i,
  input  logic             flag_clr_i,
  input  logic             irq_en_i,
  output logic [CNT_W-1:0] cap_value_o,
  output logic             cap_flag_o,
  output logic             irq_o
);
  logic             pin_sync;
  logic             pin_filt;
  logic             level_sel;
  logic             cap_ev;
  logic             flag_nxt;
  logic [CNT_W-1:0] value_r;
  logic             flag_r;
  logic             irq_r;

  icap_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .d_i (cap_pin_i),
    .q_o (pin_sync)
  );

  icap_filter #(.LEN(FILT_LEN)) u_filt (
    .clk (clk),
    .rst (rst),
    .d_i (pin_sync),
    .q_o (pin_filt)
  );

  assign level_sel = filt_en_i ? pin_filt : pin_sync;

  icap_edge u_edge (
    .clk        (clk),
    .rst        (rst),
    .level_i    (level_sel),
    .dir_i      (edge_dir_e'(edge_rise_i)),
    .gate_off_i (top_sel_i),
    .event_o    (cap_ev)
  );

  assign flag_nxt = cap_ev | (flag_r & ~flag_clr_i);

  always_ff @(posedge clk) begin
    if (rst) begin
      value_r <= '0;
      flag_r  <= 1'b0;
      irq_r   <= 1'b0;
    end else begin
      if (cap_ev) value_r <= count_i;
      flag_r <= flag_nxt;
      irq_r  <= flag_nxt & irq_en_i;
    end
  end

  assign cap_value_o = value_r;
  assign cap_flag_o  = flag_r;
  assign irq_o       = irq_r;
endmodule

// File: rtl/icap_unit_chk.sv
module icap_unit_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             cap_pin_i,
  input logic [CNT_W-1:0] count_i,
  input logic             filt_en_i,
  input logic             edge_rise_i,
  input logic             top_sel_i,
  input logic             flag_clr_i,
  input logic             irq_en_i,
  input logic [CNT_W-1:0] cap_value_o,
  input logic             cap_flag_o,
  input logic             irq_o
);
  AST_RESET_CLEAN: assert property (@(posedge clk) rst |=> (!cap_flag_o && !irq_o && cap_value_o == '0)); // R1
  AST_VALUE_SETS_FLAG: assert property (@(posedge clk) disable iff (rst) !$stable(cap_value_o) |-> cap_flag_o); // R7
  AST_FLAG_HOLDS: assert property (@(posedge clk) disable iff (rst) (cap_flag_o && !flag_clr_i) |=> cap_flag_o); // R7
  AST_GATED_NO_CAPTURE: assert property (@(posedge clk) disable iff (rst) top_sel_i |=> $stable(cap_value_o)); // R9
  AST_GATED_CLEAR: assert property (@(posedge clk) disable iff (rst) (top_sel_i && flag_clr_i) |=> !cap_flag_o); // R9
  AST_IRQ_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (rst) irq_o |-> $past(irq_en_i)); // R8
  AST_IRQ_FOLLOWS_FLAG: assert property (@(posedge clk) disable iff (rst) irq_o |-> cap_flag_o); // R8
endmodule

bind icap_unit icap_unit_chk u_chk (.*);

// File: tb/icap_unit_bench.sv
module icap_unit_bench;
  localparam int CLK_PERIOD = 10;
  localparam int CW = 16;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          pin = 1'b0;
  logic [CW-1:0] cnt = '0;
  logic          fen = 1'b0;
  logic          rise = 1'b0;
  logic          topsel = 1'b0;
  logic          clr = 1'b0;
  logic          ien = 1'b0;
  logic [CW-1:0] val;
  logic          flag;
  logic          irq;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  icap_unit u_icap_unit (
    .clk (clk), .rst (rst), .cap_pin_i (pin), .count_i (cnt),
    .filt_en_i (fen), .edge_rise_i (rise), .top_sel_i (topsel),
    .flag_clr_i (clr), .irq_en_i (ien),
    .cap_value_o (val), .cap_flag_o (flag), .irq_o (irq)
  );

  // Behavioural reference built from the requirements
  logic          m_s1, m_s2, m_filt, m_prev, m_flag, m_irq;
  logic [2:0]    m_hist;
  logic [CW-1:0] m_val;

  function automatic logic capture_due(logic lvl, logic prv, logic dir, logic gate);
    if (gate) return 1'b0;
    return dir ? (lvl && !prv) : (!lvl && prv);
  endfunction

  always @(posedge clk) begin
    logic sel, ev, nf;
    if (rst) begin
      m_s1 = 0; m_s2 = 0; m_filt = 0; m_prev = 0; m_hist = 0;
      m_flag = 0; m_irq = 0; m_val = 0;
    end else begin
      sel = fen ? m_filt : m_s2;
      ev  = capture_due(sel, m_prev, rise, topsel);
      nf  = m_filt;
      if ({m_hist, m_s2} == 4'b1111) nf = 1'b1;
      if ({m_hist, m_s2} == 4'b0000) nf = 1'b0;
      m_filt = nf;
      m_hist = {m_hist[1:0], m_s2};
      m_s2 = m_s1;
      m_s1 = pin;
      m_prev = sel;
      if (ev) m_val = cnt;
      m_flag = ev | (m_flag & !clr);
      m_irq = m_flag & ien;
    end
  end

  task automatic check(string tag, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %0h expected %0h at %0t", tag, got, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (!rst && !done) begin
      check("R6 cap_value_o", 32'(val), 32'(m_val));
      check("R7 cap_flag_o", 32'(flag), 32'(m_flag));
      check("R8 irq_o", 32'(irq), 32'(m_irq));
    end
  end

  always @(negedge clk) cnt <= cnt + 16'd7;

  task automatic cycles(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic clear_flag();
    clr = 1'b1; cycles(1); clr = 1'b0;
  endtask

  // cycles from a pin step to the flag showing
  task automatic latency(output int n);
    n = 0;
    pin = ~pin;
    while (flag !== 1'b1 && n < 30) begin
      @(negedge clk);
      n++;
    end
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    int lat_raw, lat_filt, runlen;
    logic [CW-1:0] held;
    cycles(3);
    check("R1 reset value", 32'(val), 0);
    check("R1 reset flag", 32'(flag), 0);
    check("R1 reset irq", 32'(irq), 0);
    rst = 1'b0;
    cycles(8);

    // R2: unfiltered rising edge
    rise = 1'b1; fen = 1'b0;
    latency(lat_raw);
    check("R2 unfiltered latency", 32'(lat_raw), 3);
    cycles(8); clear_flag();

    // R4: filtered latency, same direction
    pin = 1'b0; cycles(10);
    fen = 1'b1; cycles(10); clear_flag();
    latency(lat_filt);
    check("R4 filtered latency", 32'(lat_filt), 7);
    check("R4 latency difference", 32'(lat_filt - lat_raw), 4);
    cycles(8); clear_flag();

    // R3: short pulses through the filter
    pin = 1'b0; cycles(12); clear_flag();
    for (int w = 1; w <= 3; w++) begin
      pin = 1'b1; cycles(w); pin = 1'b0; cycles(12);
      check("R3 glitch ignored", 32'(flag), 0);
    end
    fen = 1'b0; cycles(4);

    // R5: falling edge with rising selected, then with falling selected
    pin = 1'b1; cycles(8); clear_flag();
    pin = 1'b0; cycles(8);
    check("R5 wrong direction", 32'(flag), 0);
    rise = 1'b0; pin = 1'b1; cycles(8);
    check("R5 rising ignored in fall mode", 32'(flag), 0);
    pin = 1'b0; cycles(8);
    check("R5 falling captured", 32'(flag), 1);
    clear_flag();

    // R10: flipping the edge select on a steady pin
    for (int k = 0; k < 6; k++) begin rise = ~rise; cycles(2); end
    check("R10 select flip no capture", 32'(flag), 0);

    // R9: gated capture, level change while gated
    held = val;
    topsel = 1'b1; rise = 1'b1; pin = 1'b1; cycles(8);
    check("R9 gated flag", 32'(flag), 0);
    check("R9 gated value", 32'(val), 32'(held));
    topsel = 1'b0; cycles(6);
    check("R9 no capture after ungating", 32'(flag), 0);

    // R7: clear coincides with capture
    pin = 1'b0; cycles(6); ien = 1'b1;
    pin = 1'b1; cycles(1);
    clr = 1'b1; cycles(2); clr = 1'b0;
    check("R7 capture beats clear", 32'(flag), 1);
    check("R8 irq with enable", 32'(irq), 1);
    ien = 1'b0; cycles(1);
    check("R8 irq drops when disabled", 32'(irq), 0);

    // random phase, checked against the model every cycle
    void'($urandom(32'h1CAB));
    for (int r = 0; r < 600; r++) begin
      runlen = 1 + ($urandom % 8);
      pin = ~pin;
      if ($urandom % 10 == 0) fen = ~fen;
      if ($urandom % 8 == 0) rise = ~rise;
      topsel = ($urandom % 6 == 0);
      ien = ($urandom % 3 != 0);
      for (int c = 0; c < runlen; c++) begin
        clr = ($urandom % 5 == 0);
        cycles(1);
      end
    end
    clr = 1'b0;
    cycles(4);
    finish_run();
  end

  initial begin
    for (int t = 0; t < 100000; t++) @(posedge clk);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end
endmodule